// File: doc/BRIEF.md
# Priority Round-Robin Crossbar Arbiter

This block decides which master owns each slave port of a crossbar that links seven masters to eight slaves. A master raises a request, names the slave it wants with a 3-bit index, and carries a 3-bit priority level, where a larger value means higher priority. Each slave port has its own arbiter, so masters that target different slaves are granted at the same time and do not affect each other. The crossbar's datapath is 32 bits of address and 64 bits of data, but that datapath is outside this block. This block only produces ownership, grant and stall.

Each slave arbiter is a two-state machine. In `SLV_IDLE` the slave has no owner. The **wait** transition (IDLE to IDLE) is taken while nobody requests the slave. The **claim** transition (IDLE to BUSY) is taken when at least one master requests it. The winner is the requester with the highest priority. A tie between equal priorities goes round-robin, starting with the master after the one last granted that slave. In `SLV_BUSY` the grant stays with its owner through the **hold** transition (BUSY to BUSY). The **release** transition (BUSY to IDLE) is taken when the owner pulses done or withdraws its request. After a release the slave is arbitrated again from IDLE.

Top module: `xbar_arb_top`

## Requirements
- R1: Masters that target distinct slaves are all granted at once. With seven masters each requesting its own slave index, all seven grant bits are high one clock after the requests appear.
- R2: A request to an idle slave gives the winner its grant one clock after the request is first sampled. No grant is given in the cycle in which the request first appears.
- R3: Among the requesters of one slave, the master with the largest 3-bit priority value wins.
- R4: Ties between equal-priority requesters are broken round-robin, starting at the master whose index follows (modulo 7) the slave's last-granted master. Each slave's last-granted register resets to master 6, so master 0 wins the first equal-priority tie.
- R5: An owner keeps its grant while it requests and has not pulsed done, even when a higher-priority master arrives. There is no preemption.
- R6: A done pulse from the owner sends the slave to idle at the next clock, with `owner_vld` low. The next winner is chosen in that idle cycle and is granted one clock later.
- R7: If the owner drops its request, or moves its slave select elsewhere, the slave becomes idle at the next clock. That master still counts as last granted for round-robin.
- R8: `stall[m]` is high exactly when `req[m]` is high and master m does not currently own the slave named by its select.
- R9: Each slave reports its owner index on its 3-bit field of `owner_id` (slave s at bits 3s+2..3s), together with an `owner_vld` bit. After reset every `owner_vld` bit and every grant bit is low.
- R10: A done pulse from a master that does not own the slave has no effect on that slave's owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 7 | Request per master |
| sel | input | 21 | Target slave per master, 3 bits each, master m at bits 3m+2..3m |
| prio | input | 21 | Priority per master, 3 bits each, larger is higher |
| done | input | 7 | Transaction-complete pulse per master |
| grant | output | 7 | Master owns its target slave |
| stall | output | 7 | Master requests but does not own its target |
| owner_id | output | 24 | Owner master index per slave, 3 bits each |
| owner_vld | output | 8 | Slave has an owner |

## Verification
A release and a competing request can land in the same cycle. The owner pulses done while another master is already waiting for that slave, and sometimes a higher-priority master joins in that same cycle. Directed sequences set this up on purpose, and the random phase does it constantly by steering all masters onto only three slaves. The bench judges the result with its own per-slave model. The model requires the waiting master to see its grant two clocks after the done pulse, not one, and to be chosen by priority and then by round-robin order from the released owner.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    typedef enum logic [0:0] {
        SLV_IDLE = 1'b0,
        SLV_BUSY = 1'b1
    } slv_state_e;

endpackage

// File: rtl/xbar_req_route.sv
// Collects, for one slave port, the masters that currently request it.
module xbar_req_route #(
    parameter int N_MST   = 7,
    parameter int SEL_W   = 3,
    parameter int SLV_IDX = 0
) (
    input  logic [N_MST-1:0]       req,
    input  logic [N_MST*SEL_W-1:0] sel,
    output logic [N_MST-1:0]       mreq
);

    localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(SLV_IDX);

    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            mreq[m] = req[m] && (sel[m*SEL_W +: SEL_W] == MY_IDX);
        end
    end

endmodule

// File: rtl/xbar_rr_pick.sv
// Highest priority wins; equal priorities rotate after the last grant.
module xbar_rr_pick #(
    parameter int N_MST  = 7,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic [N_MST-1:0]        mreq,
    input  logic [N_MST*PRIO_W-1:0] prio,
    input  logic [ID_W-1:0]         last_id,
    output logic                    any,
    output logic [ID_W-1:0]         win_id
);

    logic [PRIO_W-1:0] top_prio;
    logic              found;

    // highest priority level among the current requesters
    always_comb begin
        top_prio = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (mreq[m] && (prio[m*PRIO_W +: PRIO_W] > top_prio)) begin
                top_prio = prio[m*PRIO_W +: PRIO_W];
            end
        end
    end

    // first master at that level, scanning from last_id + 1
    always_comb begin
        any    = |mreq;
        found  = 1'b0;
        win_id = '0;
        for (int k = 1; k <= N_MST; k++) begin
            int idx;
            idx = (int'(last_id) + k) % N_MST;
            if (!found && mreq[idx] && (prio[idx*PRIO_W +: PRIO_W] == top_prio)) begin
                found  = 1'b1;
                win_id = ID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/xbar_slave_fsm.sv
// Ownership state machine for a single slave port.
module xbar_slave_fsm
    import xbar_arb_pkg::*;
#(
    parameter int N_MST  = 7,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        mreq,
    input  logic [N_MST*PRIO_W-1:0] prio,
    input  logic [N_MST-1:0]        done,
    output logic [ID_W-1:0]         owner_id,
    output logic                    owner_vld
);

    localparam logic [ID_W-1:0] LAST_RST = ID_W'(N_MST - 1);

    slv_state_e      state_q, state_d;
    logic [ID_W-1:0] own_q, own_d;
    logic [ID_W-1:0] last_q, last_d;
    logic            pick_any;
    logic [ID_W-1:0] pick_id;
    logic            own_req, own_done;

    xbar_rr_pick #(
        .N_MST  (N_MST),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_pick (
        .mreq    (mreq),
        .prio    (prio),
        .last_id (last_q),
        .any     (pick_any),
        .win_id  (pick_id)
    );

    assign own_req  = mreq[own_q];
    assign own_done = done[own_q];

    // next-state and transition logic
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        last_d  = last_q;
        unique case (state_q)
            SLV_IDLE: begin
                if (pick_any) begin           // claim
                    state_d = SLV_BUSY;
                    own_d   = pick_id;
                    last_d  = pick_id;
                end
            end
            SLV_BUSY: begin
                if (!own_req || own_done) begin  // release
                    state_d = SLV_IDLE;
                end
            end
            default: state_d = SLV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLV_IDLE;
            own_q   <= '0;
            last_q  <= LAST_RST;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            last_q  <= last_d;
        end
    end

    // outputs
    always_comb begin
        owner_vld = (state_q == SLV_BUSY);
        owner_id  = own_q;
    end

    // winner is no lower than any requester (R3)
    logic pick_is_max;
    always_comb begin
        pick_is_max = 1'b1;
        for (int m = 0; m < N_MST; m++) begin
            if (mreq[m] && (prio[m*PRIO_W +: PRIO_W] > prio[int'(pick_id)*PRIO_W +: PRIO_W])) begin
                pick_is_max = 1'b0;
            end
        end
    end

    assert_prio_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_IDLE && pick_any) |-> pick_is_max);

    assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_IDLE && (|mreq)) |=>
            (state_q == SLV_BUSY && (($past(mreq) >> own_q) & N_MST'(1)) != '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_BUSY && mreq[own_q] && !done[own_q]) |=>
            (state_q == SLV_BUSY && $stable(own_q)));

    assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_BUSY && done[own_q]) |=> (state_q == SLV_IDLE));

    assert_drop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_BUSY && !mreq[own_q]) |=> (state_q == SLV_IDLE));

    assert_last_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLV_BUSY) |-> (last_q == own_q));

endmodule

// File: rtl/xbar_arb_top.sv
module xbar_arb_top
    import xbar_arb_pkg::*;
#(
    parameter int N_MST  = 7,
    parameter int N_SLV  = 8,
    parameter int PRIO_W = 3,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST*SEL_W-1:0]  sel,
    input  logic [N_MST*PRIO_W-1:0] prio,
    input  logic [N_MST-1:0]        done,
    output logic [N_MST-1:0]        grant,
    output logic [N_MST-1:0]        stall,
    output logic [N_SLV*3-1:0]      owner_id,
    output logic [N_SLV-1:0]        owner_vld
);

    localparam int ID_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [ID_W-1:0] slv_own [N_SLV];
    logic            slv_vld [N_SLV];

    for (genvar s = 0; s < N_SLV; s++) begin : g_slv
        logic [N_MST-1:0] mreq_s;

        xbar_req_route #(
            .N_MST   (N_MST),
            .SEL_W   (SEL_W),
            .SLV_IDX (s)
        ) u_route (
            .req  (req),
            .sel  (sel),
            .mreq (mreq_s)
        );

        xbar_slave_fsm #(
            .N_MST  (N_MST),
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .mreq      (mreq_s),
            .prio      (prio),
            .done      (done),
            .owner_id  (slv_own[s]),
            .owner_vld (slv_vld[s])
        );

        assign owner_vld[s]          = slv_vld[s];
        assign owner_id[s*3 +: 3]    = 3'(slv_own[s]);
    end

    // per-master grant: owner of the slave it currently names
    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            int t;
            t = int'(sel[m*SEL_W +: SEL_W]);
            grant[m] = 1'b0;
            if (req[m] && (t < N_SLV)) begin
                grant[m] = slv_vld[t] && (slv_own[t] == ID_W'(m));
            end
            stall[m] = req[m] && !grant[m];
        end
    end

    assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

endmodule

// File: tb/sim_xbar_arb_top.sv
`timescale 1ns/1ps
module sim_xbar_arb_top;

    localparam int NM = 7;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic [NM*3-1:0] sel = '0;
    logic [NM*3-1:0] prio = '0;
    logic [NM-1:0] done = '0;
    logic [NM-1:0] grant, stall;
    logic [NS*3-1:0] owner_id;
    logic [NS-1:0] owner_vld;

    int vectors = 0;
    int errors  = 0;

    // bench model of each slave
    bit m_busy [NS];
    int m_own  [NS];
    int m_last [NS];

    always #10 clk = ~clk;

    xbar_arb_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .sel       (sel),
        .prio      (prio),
        .done      (done),
        .grant     (grant),
        .stall     (stall),
        .owner_id  (owner_id),
        .owner_vld (owner_vld)
    );

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sel_of(int m);
        return int'(sel[m*3 +: 3]);
    endfunction

    function automatic int prio_of(int m);
        return int'(prio[m*3 +: 3]);
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_busy[s] = 1'b0;
            m_own[s]  = 0;
            m_last[s] = NM - 1;
        end
    endtask

    // apply one clock edge to the model using the current inputs
    task automatic model_step();
        for (int s = 0; s < NS; s++) begin
            if (m_busy[s]) begin
                int o;
                o = m_own[s];
                if (!(req[o] && sel_of(o) == s) || done[o]) m_busy[s] = 1'b0;
            end else begin
                int best;
                int pick;
                best = -1;
                pick = -1;
                for (int m = 0; m < NM; m++)
                    if (req[m] && sel_of(m) == s && prio_of(m) > best) best = prio_of(m);
                for (int k = 1; k <= NM; k++) begin
                    int i;
                    i = (m_last[s] + k) % NM;
                    if (pick < 0 && req[i] && sel_of(i) == s && prio_of(i) == best) pick = i;
                end
                if (pick >= 0) begin
                    m_busy[s] = 1'b1;
                    m_own[s]  = pick;
                    m_last[s] = pick;
                end
            end
        end
    endtask

    task automatic compare_all(string tag);
        for (int m = 0; m < NM; m++) begin
            int t;
            bit g;
            t = sel_of(m);
            g = req[m] && m_busy[t] && (m_own[t] == m);
            check({tag, " grant"}, int'(grant[m]), int'(g));
            check({tag, " stall R8"}, int'(stall[m]), int'(req[m] && !g));
        end
        for (int s = 0; s < NS; s++) begin
            check({tag, " owner_vld R9"}, int'(owner_vld[s]), int'(m_busy[s]));
            if (m_busy[s]) check({tag, " owner_id R9"}, int'(owner_id[s*3 +: 3]), m_own[s]);
        end
    endtask

    // inputs were set at a falling edge; compare, then cross one rising edge
    task automatic tick(string tag);
        #1;
        compare_all(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic set_m(int m, bit r, int s, int p);
        req[m] = r;
        sel[m*3 +: 3] = 3'(s);
        prio[m*3 +: 3] = 3'(p);
    endtask

    function automatic int own_of(int s);
        return int'(owner_id[s*3 +: 3]);
    endfunction

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check("R9 reset grant", int'(grant), 0);
        check("R9 reset owner_vld", int'(owner_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R2 / R6: all masters tie on slave 0
        for (int m = 0; m < NM; m++) set_m(m, 1, 0, 2);
        #1;
        check("R2 no grant same cycle", int'(grant), 0);
        tick("R2");
        check("R4 first tie goes to master 0", own_of(0), 0);
        check("R2 grant after one clock", int'(grant[0]), 1);
        done[0] = 1'b1;
        tick("R6");
        done[0] = 1'b0;
        check("R6 idle after done", int'(owner_vld[0]), 0);
        tick("R6");
        check("R4 rotates to master 1", own_of(0), 1);
        req = '0;
        tick("R7");

        // R3 then R7 then R5 then R10 on slave 1
        set_m(2, 1, 1, 1);
        set_m(5, 1, 1, 7);
        tick("R3");
        check("R3 higher priority wins", own_of(1), 5);
        req[5] = 1'b0;
        tick("R7");
        check("R7 release on drop", int'(owner_vld[1]), 0);
        tick("R7");
        check("R7 remaining requester", own_of(1), 2);
        set_m(4, 1, 1, 7);
        tick("R5");
        check("R5 no preemption", own_of(1), 2);
        done[4] = 1'b1;
        tick("R10");
        done[4] = 1'b0;
        check("R10 non-owner done ignored", own_of(1), 2);
        check("R10 owner still valid", int'(owner_vld[1]), 1);
        req = '0;
        tick("R7");

        // R7 last-granted still updated after a drop, slave 2
        set_m(3, 1, 2, 0);
        set_m(4, 1, 2, 0);
        set_m(5, 1, 2, 0);
        tick("R4");
        check("R4 tie on slave 2 starts at 3", own_of(2), 3);
        req[3] = 1'b0;
        tick("R7");
        req[3] = 1'b1;
        tick("R7");
        check("R7 last id kept at dropped master", own_of(2), 4);
        req = '0;
        tick("R7");

        // R1 independent slaves
        for (int m = 0; m < NM; m++) set_m(m, 1, m, 0);
        tick("R1");
        check("R1 all granted", int'(grant), 7'h7f);
        check("R8 no stall", int'(stall), 0);
        req = '0;
        tick("R1");

        // random contention on three slaves
        for (int c = 0; c < 4000; c++) begin
            for (int m = 0; m < NM; m++) begin
                if ($urandom % 6 == 0) req[m] = ~req[m];
                if (!req[m] || $urandom % 16 == 0) sel[m*3 +: 3] = 3'($urandom % 3);
                if ($urandom % 10 == 0) prio[m*3 +: 3] = 3'($urandom % 4);
                done[m] = grant[m] && ($urandom % 4 == 0);
            end
            tick("R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule